// File: doc/BRIEF.md
# Parity-Protected Word Write Receiver

This block takes in a serial write frame, one bit per cycle in which the bit-valid strobe is high. It collects an address nibble and a 16-bit data word and decides whether the write may proceed. Each of the five nibbles (the address and four data nibbles) is followed by its own even parity bit. A closing block holds one even parity bit per bit column of the data word and a final zero. After the last bit the block checks every parity bit and the lock bit of the target address. It then either refuses the write, starts the write and acknowledges it, or drops the frame without a reply.

A nonvolatile memory controller sits on the far side. It receives the address, the data and a one-cycle start strobe, and it reports completion on a done input. An accepted write is acknowledged twice: once when programming starts and once after the done input arrives. After any outcome the receiver goes back to standby, ready for the first bit of the next frame.

Top module: `word_write_rx`

## Requirements
- R1: A frame is 30 bits in six 5-bit blocks, each block sent most significant bit first. The blocks come in this order: A3..A0 then address parity; D15..D12 then P3; D11..D08 then P2; D07..D04 then P1; D03..D00 then P0; PC3..PC0 then one zero bit. After an accepted frame, `wr_addr_o` holds A3..A0 and `wr_data_o` holds D15..D00.
- R2: If the address nibble and its parity bit together hold an odd number of ones, the frame is refused with NAK.
- R3: If any data nibble and its row parity bit together hold an odd number of ones, the frame is refused with NAK.
- R4: If the column check fails, the frame is refused with NAK. The check requires that PCn, D(12+n), D(8+n), D(4+n) and D(n) together hold an even number of ones, for each n in 0..3.
- R5: If `lock_i[addr]` is 1 for the received address, the frame is refused with NAK, even when every parity bit is correct.
- R6: If the final bit of the frame is 1, the block returns to standby silently: no ACK, no NAK and no program start. The next frame is received normally.
- R7: For a frame that passes every check, `ack_o` and `prog_start_o` are high together for exactly one cycle. That cycle follows the clock edge that captured the last bit.
- R8: After the first ACK, `ack_o` stays low until `prog_done_i` is sampled high. `ack_o` then goes high for one cycle, in the cycle after that sampling edge.
- R9: Bits presented while a frame is being evaluated or programmed are ignored. The write address and data stay unchanged, and the next frame after standby aligns from its first bit.
- R10: After reset, `ack_o`, `nak_o` and `prog_start_o` are low and the receiver waits for the first bit of a frame.
- R11: `ack_o` and `nak_o` are never high in the same cycle. A NAK lasts one cycle, after which the block is in standby at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial frame bit |
| bit_vld_i | input | 1 | `bit_i` is valid this cycle |
| lock_i | input | 16 | Per-address lock bits; 1 means the address is write-protected |
| prog_done_i | input | 1 | Memory controller has finished programming |
| wr_addr_o | output | 4 | Write address |
| wr_data_o | output | 16 | Write data |
| prog_start_o | output | 1 | One-cycle strobe that starts programming |
| ack_o | output | 1 | Acknowledge request, one cycle |
| nak_o | output | 1 | Refusal request, one cycle |

## Verification
The assertions assume that `prog_done_i` is raised only while the block waits for programming to finish. They also assume that every input holds a defined value once reset is released. The stimulus changes inputs only on falling clock edges, and it pulses the done input only after it has seen the first acknowledge. It offers stray serial bits during the evaluation and programming phases, so that the frame stays frozen under real traffic.

// File: rtl/wwr_pkg.sv
package wwr_pkg;
  typedef enum logic [1:0] {
    ST_RECV = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK2 = 2'd3
  } wwr_state_e;
endpackage

// File: rtl/wwr_deser.sv
module wwr_deser #(
  parameter int NIB_W   = 4,
  parameter int NUM_BLK = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           shift_i,
  input  logic                           bit_i,
  output logic [(NIB_W+1)*NUM_BLK-1:0]   frame_o,
  output logic                           last_o
);
  localparam int BLK_W   = NIB_W + 1;
  localparam int FRAME_W = BLK_W * NUM_BLK;
  localparam int BC_W    = $clog2(BLK_W);
  localparam int KC_W    = $clog2(NUM_BLK);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(BLK_W - 1);
  localparam logic [KC_W-1:0] BLK_LAST = KC_W'(NUM_BLK - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [BC_W-1:0]    bit_cnt_q;
  logic [KC_W-1:0]    blk_cnt_q;

  assign last_o  = shift_i && (bit_cnt_q == BIT_LAST) && (blk_cnt_q == BLK_LAST);
  assign frame_o = frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= '0;
      bit_cnt_q <= '0;
      blk_cnt_q <= '0;
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], bit_i};
      if (bit_cnt_q == BIT_LAST) begin
        bit_cnt_q <= '0;
        blk_cnt_q <= (blk_cnt_q == BLK_LAST) ? '0 : blk_cnt_q + 1'b1;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  // R1
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_q <= BIT_LAST) && (blk_cnt_q <= BLK_LAST));

  // R11
  frame_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (bit_cnt_q == '0) && (blk_cnt_q == '0));
endmodule

// File: rtl/wwr_check.sv
module wwr_check #(
  parameter int NIB_W     = 4,
  parameter int DATA_NIBS = 4
) (
  input  logic [(NIB_W+1)*(DATA_NIBS+2)-1:0] frame_i,
  output logic [NIB_W-1:0]                   addr_o,
  output logic [NIB_W*DATA_NIBS-1:0]         data_o,
  output logic                               par_ok_o,
  output logic                               tail_ok_o
);
  localparam int BLK_W   = NIB_W + 1;
  localparam int NUM_ROW = DATA_NIBS + 1;
  localparam int FRAME_W = BLK_W * (DATA_NIBS + 2);

  logic [NUM_ROW-1:0] row_ok;
  logic [NIB_W-1:0]   col_acc;

  // row 0 is the address block, rows 1.. are data blocks, high nibble first
  for (genvar r = 0; r < NUM_ROW; r++) begin : g_row
    assign row_ok[r] = ~^frame_i[FRAME_W-1-r*BLK_W -: BLK_W];
  end

  for (genvar k = 0; k < DATA_NIBS; k++) begin : g_data
    assign data_o[(DATA_NIBS-1-k)*NIB_W +: NIB_W] = frame_i[FRAME_W-1-(k+1)*BLK_W -: NIB_W];
  end

  always_comb begin
    col_acc = frame_i[BLK_W-1 -: NIB_W];
    for (int k = 0; k < DATA_NIBS; k++) col_acc ^= data_o[k*NIB_W +: NIB_W];
  end

  assign addr_o    = frame_i[FRAME_W-1 -: NIB_W];
  assign par_ok_o  = (&row_ok) && (col_acc == '0);
  assign tail_ok_o = ~frame_i[0];
endmodule

// File: rtl/wwr_ctrl.sv
module wwr_ctrl
  import wwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic last_i,
  input  logic frame_ok_i,
  input  logic tail_ok_i,
  input  logic prog_done_i,
  output logic shift_o,
  output logic ack_o,
  output logic nak_o,
  output logic prog_start_o
);
  wwr_state_e state_q, state_d;
  logic       accept;

  assign shift_o      = bit_vld_i && (state_q == ST_RECV);
  assign accept       = (state_q == ST_EVAL) && tail_ok_i && frame_ok_i;
  assign prog_start_o = accept;
  assign ack_o        = accept || (state_q == ST_ACK2);
  assign nak_o        = (state_q == ST_EVAL) && tail_ok_i && !frame_ok_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECV: if (last_i) state_d = ST_EVAL;
      ST_EVAL: state_d = accept ? ST_WAIT : ST_RECV;
      ST_WAIT: if (prog_done_i) state_d = ST_ACK2;
      ST_ACK2: state_d = ST_RECV;
      default: state_d = ST_RECV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RECV;
    else         state_q <= state_d;
  end

  // R11
  ack_nak_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && nak_o));

  // R11
  nak_to_standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_o |=> (state_q == ST_RECV) && !nak_o);

  // R7
  start_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> ack_o && !nak_o);

  // R8
  no_early_ack2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> !ack_o && !prog_start_o);

  // R6
  silent_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EVAL) && !tail_ok_i) |=> (state_q == ST_RECV) && !ack_o);
endmodule

// File: rtl/word_write_rx.sv
module word_write_rx #(
  parameter int NIB_W     = 4,
  parameter int DATA_NIBS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bit_i,
  input  logic                       bit_vld_i,
  input  logic [(2**NIB_W)-1:0]      lock_i,
  input  logic                       prog_done_i,
  output logic [NIB_W-1:0]           wr_addr_o,
  output logic [NIB_W*DATA_NIBS-1:0] wr_data_o,
  output logic                       prog_start_o,
  output logic                       ack_o,
  output logic                       nak_o
);
  localparam int NUM_BLK = DATA_NIBS + 2;
  localparam int FRAME_W = (NIB_W + 1) * NUM_BLK;

  logic [FRAME_W-1:0] frame;
  logic shift, last, par_ok, tail_ok, frame_ok;

  wwr_deser #(.NIB_W(NIB_W), .NUM_BLK(NUM_BLK)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .bit_i   (bit_i),
    .frame_o (frame),
    .last_o  (last)
  );

  wwr_check #(.NIB_W(NIB_W), .DATA_NIBS(DATA_NIBS)) u_check (
    .frame_i   (frame),
    .addr_o    (wr_addr_o),
    .data_o    (wr_data_o),
    .par_ok_o  (par_ok),
    .tail_ok_o (tail_ok)
  );

  assign frame_ok = par_ok && !lock_i[wr_addr_o];

  wwr_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_vld_i    (bit_vld_i),
    .last_i       (last),
    .frame_ok_i   (frame_ok),
    .tail_ok_i    (tail_ok),
    .prog_done_i  (prog_done_i),
    .shift_o      (shift),
    .ack_o        (ack_o),
    .nak_o        (nak_o),
    .prog_start_o (prog_start_o)
  );

  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |=> $stable(wr_addr_o) && $stable(wr_data_o));

  // R5
  lock_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && prog_start_o) |-> !lock_i[wr_addr_o]);
endmodule

// File: tb/word_write_rx_test.sv
module word_write_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0, vld = 1'b0, done = 1'b0;
  logic [15:0] lock = '0;
  logic [3:0]  addr;
  logic [15:0] data;
  logic        prog_start, ack, nak;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  word_write_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(vld), .lock_i(lock),
    .prog_done_i(done), .wr_addr_o(addr), .wr_data_o(data),
    .prog_start_o(prog_start), .ack_o(ack), .nak_o(nak)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [29:0] mk(input logic [3:0] a, input logic [15:0] d, input int flip);
    logic [29:0] f;
    logic [3:0]  pc;
    pc = d[15:12] ^ d[11:8] ^ d[7:4] ^ d[3:0];
    f = {a, ^a, d[15:12], ^d[15:12], d[11:8], ^d[11:8], d[7:4], ^d[7:4], d[3:0], ^d[3:0], pc, 1'b0};
    if (flip >= 0) f[flip] = ~f[flip];
    return f;
  endfunction

  task automatic send(input logic [29:0] f);
    for (int i = 29; i >= 0; i--) begin
      @(negedge clk); bit_in = f[i]; vld = 1'b1;
    end
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic outs(input string req, input logic a, input logic n, input logic p);
    chk({ack, nak, prog_start} == {a, n, p}, req, {ack, nak, prog_start}, {a, n, p});
  endtask

  // good write: ACK + start, wait, done, second ACK
  task automatic t_good(input logic [3:0] a, input logic [15:0] d, input bit stray);
    send(mk(a, d, -1));
    outs("R7 first ack", 1, 0, 1);
    chk(addr == a, "R1 addr", addr, a);
    chk(data == d, "R1 data", data, d);
    @(negedge clk);
    outs("R8 quiet wait", 0, 0, 0);
    if (stray) begin
      for (int i = 0; i < 7; i++) begin
        @(negedge clk); bit_in = i[0]; vld = 1'b1;
      end
      @(negedge clk); vld = 1'b0;
      chk(data == d, "R9 data held", data, d);
      chk(addr == a, "R9 addr held", addr, a);
    end
    repeat (2) @(negedge clk);
    outs("R8 no ack before done", 0, 0, 0);
    done = 1'b1;
    @(negedge clk); done = 1'b0;
    outs("R8 second ack", 1, 0, 0);
    @(negedge clk);
    outs("R8 ack one cycle", 0, 0, 0);
  endtask

  task automatic t_nak(input string req, input logic [3:0] a, input logic [15:0] d, input int flip);
    send(mk(a, d, flip));
    outs(req, 0, 1, 0);
    @(negedge clk);
    outs("R11 nak one cycle", 0, 0, 0);
  endtask

  task automatic t_tail();
    send(mk(4'h5, 16'h1234, 0));
    outs("R6 silent", 0, 0, 0);
    @(negedge clk);
    outs("R6 still silent", 0, 0, 0);
    t_good(4'h5, 16'h1234, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    outs("R10 reset outputs", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R10 idle after reset", 0, 0, 0);
    t_good(4'h3, 16'hA5C3, 1'b0);                   // R1 R7 R8
    t_good(4'hF, 16'hFFFF, 1'b1);                   // R9
    t_good(4'h0, 16'h0000, 1'b0);
    t_nak("R2 addr parity", 4'h6, 16'h0F0F, 25);
    t_nak("R3 row parity", 4'h6, 16'h0F0F, 10);
    t_nak("R4 column parity", 4'h6, 16'h0F0F, 2);
    lock[4'h9] = 1'b1;
    t_nak("R5 locked", 4'h9, 16'h8001, -1);
    t_good(4'h8, 16'h8001, 1'b0);                   // R5 neighbour unlocked
    lock = '0;
    t_tail();                                       // R6
    t_good(4'h1, 16'h7E81, 1'b0);                   // R11 realigned after nak
    summary();
  end
endmodule